// File: doc/BRIEF.md
# PLL Control Word Rate Calculator

This block takes a 32-bit PLL control word and a reference frequency in Hz and reports the frequency the PLL would produce with that setting. It splits the word into its divider fields and its power-down and bypass flags. If either flag is set, it answers at once. If neither is set, it forms the product of the reference and the feedback multiplier at 64-bit width. It then divides that product by the combined input and output divider, using a restoring shift-subtract divider that takes one quotient bit per cycle.

A caller places the word and the reference on the inputs and pulses `start_i`. When `done_o` pulses, the caller reads `freq_o` along with the decoded flags. The flags stay visible until the next accepted start. A start that arrives while a division is running is dropped.

Top module: `pll_rate_calc`

## Requirements
- R1: When bit 0 (power-down) of the accepted word is 1, `freq_o` is 0 and `done_o` is high in the first cycle after the start edge.
- R2: When bit 0 is 0 and bit 1 (bypass) is 1, `freq_o` equals the reference sampled with the start, and `done_o` is high in the first cycle after the start edge.
- R3: Power-down takes priority over bypass: a word with both bits set reports 0.
- R4: The divider fields are read from fixed bit positions: output divider code at bits 3:2, input divider code at bits 8:4, feedback code at bits 15:9. Bits 31:16 have no effect on the result.
- R5: When neither flag is set, `freq_o` is the low 32 bits of floor(ref * 2*(fb+1) / ((in+1) * 2^out)). The product is formed at 64 bits, so a product wider than 32 bits keeps its upper bits through the division.
- R6: A computed result gives `done_o` in the 65th cycle after the cycle that holds the start edge, that is, after 66 rising edges counting the one that samples the start.
- R7: `done_o` is high for exactly one cycle for each accepted start.
- R8: A start that arrives while a division is in progress is ignored: the result, the flags and the number of done pulses are unchanged.
- R9: `pwr_down_o` and `bypass_o` show bits 0 and 1 of the last accepted word and hold their values until the next accepted start.
- R10: After reset, `freq_o`, `done_o`, `pwr_down_o` and `bypass_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| ctrl_word_i | input | 32 | PLL control word |
| ref_freq_i | input | 32 | Reference frequency in Hz |
| freq_o | output | 32 | Resulting output frequency in Hz |
| done_o | output | 1 | One-cycle result-valid pulse |
| pwr_down_o | output | 1 | Power-down flag of the accepted word |
| bypass_o | output | 1 | Bypass flag of the accepted word |

## Verification
The hardest case to reach from the ports is a second start that lands in the middle of a division. It has to be shown that this start leaves the running quotient, the latched flags and the done count untouched. The stimulus launches a computed setting and then, partway through the 64 divide steps, pulses start with a power-down word. The bench then confirms three things: the original quotient arrives on time, the flags still show the first word, and no second done pulse follows. Quotient truncation is also exercised: a full-scale reference is paired with the largest feedback code, so the product exceeds 32 bits before the division.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;

    localparam int PD_BIT    = 0;
    localparam int BYP_BIT   = 1;
    localparam int ODIV_LSB  = 2;
    localparam int ODIV_W    = 2;
    localparam int IDIV_LSB  = 4;
    localparam int IDIV_W    = 5;
    localparam int FBDIV_LSB = 9;
    localparam int FBDIV_W   = 7;

    typedef struct packed {
        logic               pwr_down;
        logic               bypass;
        logic [ODIV_W-1:0]  out_code;
        logic [IDIV_W-1:0]  in_code;
        logic [FBDIV_W-1:0] fb_code;
    } pll_fields_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } calc_state_t;

endpackage

// File: rtl/pll_field_decode.sv
module pll_field_decode
    import pll_rate_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_i,
    output pll_fields_t       fields_o
);

    always_comb begin
        fields_o.pwr_down = word_i[PD_BIT];
        fields_o.bypass   = word_i[BYP_BIT];
        fields_o.out_code = word_i[ODIV_LSB  +: ODIV_W];
        fields_o.in_code  = word_i[IDIV_LSB  +: IDIV_W];
        fields_o.fb_code  = word_i[FBDIV_LSB +: FBDIV_W];
    end

endmodule

// File: rtl/pll_operand_gen.sv
module pll_operand_gen
    import pll_rate_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int PROD_W = 64
) (
    input  pll_fields_t       fields_i,
    input  logic [FREQ_W-1:0] ref_i,
    output logic [PROD_W-1:0] dividend_o,
    output logic [PROD_W-1:0] divisor_o
);

    localparam int FB_EFF_W = FBDIV_W + 2;
    localparam int IN_EFF_W = IDIV_W + 1;
    localparam int N_SHIFT  = 2 ** ODIV_W;
    localparam int DIVR_W   = IN_EFF_W + N_SHIFT - 1;

    logic [FB_EFF_W-1:0] fb_eff;
    logic [IN_EFF_W-1:0] in_eff;
    logic [DIVR_W-1:0]   shift_cand [N_SHIFT];

    always_comb begin
        fb_eff = (FB_EFF_W'(fields_i.fb_code) + FB_EFF_W'(1)) << 1;
        in_eff = IN_EFF_W'(fields_i.in_code) + IN_EFF_W'(1);
    end

    for (genvar g = 0; g < N_SHIFT; g++) begin : g_out_div
        assign shift_cand[g] = DIVR_W'(in_eff) << g;
    end

    always_comb begin
        dividend_o = PROD_W'(ref_i) * PROD_W'(fb_eff);
        divisor_o  = PROD_W'(shift_cand[fields_i.out_code]);
    end

endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int W = 64
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         valid_o,
    output logic [W-1:0] quot_o
);

    localparam int CNT_W = $clog2(W);

    typedef struct packed {
        logic             busy;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     dvs;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [W:0] trial;
    logic       take;

    always_comb begin
        s_d     = s_q;
        s_d.valid = 1'b0;
        trial   = {s_q.rem, s_q.quo[W-1]};
        take    = (trial >= {1'b0, s_q.dvs});
        if (load_i && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.rem  = '0;
            s_d.quo  = dividend_i;
            s_d.dvs  = divisor_i;
        end else if (s_q.busy) begin
            if (take) begin
                s_d.rem = W'(trial - {1'b0, s_q.dvs});
            end else begin
                s_d.rem = trial[W-1:0];
            end
            s_d.quo = {s_q.quo[W-2:0], take};
            s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.cnt == CNT_W'(W - 1)) begin
                s_d.busy  = 1'b0;
                s_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = s_q.busy;
    assign valid_o = s_q.valid;
    assign quot_o  = s_q.quo;

    // R7: the divider reports each quotient for a single cycle
    a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R5: a zero divisor never reaches the divider
    a_r5_divisor_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |-> divisor_i != '0);

    // R6: a new division starts its step count from zero
    a_r6_busy_starts_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> s_q.cnt == '0);

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_rate_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int FREQ_W = 32,
    parameter int PROD_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [WORD_W-1:0] ctrl_word_i,
    input  logic [FREQ_W-1:0] ref_freq_i,
    output logic [FREQ_W-1:0] freq_o,
    output logic              done_o,
    output logic              pwr_down_o,
    output logic              bypass_o
);

    typedef struct packed {
        calc_state_t       state;
        logic [FREQ_W-1:0] freq;
        logic              done;
        logic              pd;
        logic              byp;
    } top_state_t;

    top_state_t  r_d, r_q;
    pll_fields_t fields;
    logic [PROD_W-1:0] dividend, divisor, quot;
    logic div_load, div_busy, div_valid;

    pll_field_decode #(.WORD_W(WORD_W)) u_decode (
        .word_i   (ctrl_word_i),
        .fields_o (fields)
    );

    pll_operand_gen #(.FREQ_W(FREQ_W), .PROD_W(PROD_W)) u_operands (
        .fields_i   (fields),
        .ref_i      (ref_freq_i),
        .dividend_o (dividend),
        .divisor_o  (divisor)
    );

    pll_seq_div #(.W(PROD_W)) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (div_load),
        .dividend_i (dividend),
        .divisor_i  (divisor),
        .busy_o     (div_busy),
        .valid_o    (div_valid),
        .quot_o     (quot)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        div_load = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.pd  = fields.pwr_down;
                    r_d.byp = fields.bypass;
                    if (fields.pwr_down) begin
                        r_d.freq = '0;
                        r_d.done = 1'b1;
                    end else if (fields.bypass) begin
                        r_d.freq = ref_freq_i;
                        r_d.done = 1'b1;
                    end else begin
                        div_load  = 1'b1;
                        r_d.state = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (div_valid) begin
                    r_d.freq  = quot[FREQ_W-1:0];
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign freq_o     = r_q.freq;
    assign done_o     = r_q.done;
    assign pwr_down_o = r_q.pd;
    assign bypass_o   = r_q.byp;

    // R1/R3: a power-down result is always zero
    a_r3_pd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && pwr_down_o |-> freq_o == '0);

    // R2: bypass passes the reference sampled with the start
    a_r2_bypass_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !pwr_down_o && bypass_o |-> freq_o == $past(ref_freq_i));

    // R8: a start during a division leaves the flags alone
    a_r8_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RUN) && start_i |=> $stable(pwr_down_o) && $stable(bypass_o));

    // R6: no done while the divider is still working
    a_r6_no_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RUN) && !div_valid |=> !done_o);

    // R8: the divider is never reloaded while running
    a_r8_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_busy |-> !div_load);

endmodule

// File: tb/pll_rate_calc_tb_top.sv
module pll_rate_calc_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] word = '0;
    logic [31:0] refq = '0;
    logic [31:0] freq;
    logic        done, pd, byp;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_rate_calc dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .ctrl_word_i (word),
        .ref_freq_i  (refq),
        .freq_o      (freq),
        .done_o      (done),
        .pwr_down_o  (pd),
        .bypass_o    (byp)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic logic [31:0] mk(input bit p, input bit b, input int o,
                                       input int i, input int f, input logic [15:0] up);
        return {up, f[6:0], i[4:0], o[1:0], b, p};
    endfunction

    function automatic logic [31:0] model(input logic [31:0] w, input logic [31:0] r);
        longint unsigned prod, dv, q;
        if (w[0]) return 32'd0;
        if (w[1]) return r;
        prod = longint'(r) * (2 * (longint'(w[15:9]) + 1));
        dv   = (longint'(w[8:4]) + 1) << w[3:2];
        q    = prod / dv;
        return q[31:0];
    endfunction

    // launch one request and check value, latency, flags and pulse width
    task automatic run(input logic [31:0] w, input logic [31:0] r, input string req);
        logic [31:0] exp;
        int edges;
        int exp_lat;
        bit seen;
        exp     = model(w, r);
        exp_lat = (w[0] || w[1]) ? 1 : 66;
        @(negedge clk);
        word  = w;
        refq  = r;
        start = 1'b1;
        @(posedge clk);
        edges = 1;
        @(negedge clk);
        start = 1'b0;
        seen  = 1'b0;
        for (int k = 0; k < 100; k++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        check(seen, "R6 done seen", longint'(seen), 1);
        if (seen) begin
            check(freq == exp, req, freq, exp);
            check(edges == exp_lat, "R6 latency", edges, exp_lat);
            check(pd == w[0] && byp == w[1], "R9 flags", {pd, byp}, {w[0], w[1]});
            @(negedge clk);
            check(!done, "R7 single pulse", done, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [31:0] w1, w2, exp1;
        int pulses;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        // R10: reset state
        check(freq == 0 && !done && !pd && !byp, "R10 reset", {freq, done, pd, byp}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3 power-down
        run(mk(1, 0, 2, 7, 40, 16'h0000), 32'd25_000_000, "R1 power-down");
        run(mk(1, 1, 1, 3, 99, 16'hABCD), 32'd48_000_000, "R3 pd over bypass");
        // R2 bypass
        run(mk(0, 1, 3, 31, 127, 16'h1234), 32'd33_000_000, "R2 bypass");
        run(mk(0, 1, 0, 0, 0, 16'h0000), 32'hFFFF_FFFF, "R2 bypass max");

        // R5 sweep over input and output divider codes
        for (int i = 0; i < 32; i++) begin
            for (int o = 0; o < 4; o++) begin
                run(mk(0, 0, o, i, (i * 5 + o * 17) % 128, 16'h0),
                    32'd33_333_333 + 32'(i * 1000 + o), "R5 div sweep");
            end
        end
        // R5 sweep over feedback codes
        for (int f = 0; f < 128; f++) begin
            run(mk(0, 0, f % 4, f % 32, f, 16'h0), 32'd27_000_000, "R5 fb sweep");
        end
        // R5 truncation and 64-bit product
        run(mk(0, 0, 0, 2, 0, 16'h0), 32'd100, "R5 truncation");
        run(mk(0, 0, 0, 0, 127, 16'h0), 32'hFFFF_FFFF, "R5 wide product");
        run(mk(0, 0, 3, 31, 0, 16'h0), 32'd7, "R5 small quotient");

        // R4 upper bits have no effect
        for (int u = 0; u < 16; u++) begin
            run(mk(0, 0, u % 4, (u * 3) % 32, (u * 11) % 128, 16'(u * 16'h1357 + 16'h8001)),
                32'd100_000_000, "R4 upper bits ignored");
        end

        // R8 start while busy is ignored
        w1   = mk(0, 0, 1, 1, 35, 16'h0);
        w2   = mk(1, 1, 0, 0, 0, 16'h0);
        exp1 = model(w1, 32'd50_000_000);
        @(negedge clk);
        word = w1; refq = 32'd50_000_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pulses = 0;
        for (int k = 0; k < 20; k++) @(negedge clk);
        word = w2; refq = 32'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 120; k++) begin
            if (done) begin
                pulses++;
                check(freq == exp1, "R8 result kept", freq, exp1);
                check(!pd && !byp, "R8 flags kept", {pd, byp}, 0);
            end
            @(negedge clk);
        end
        check(pulses == 1, "R8 one done pulse", pulses, 1);
        check(!pd && !byp, "R9 flags held", {pd, byp}, 0);

        finish_run();
    end

endmodule